// File: doc/BRIEF.md
# Semidynamic Divisor Multiple Generator

This block produces the signed multiple q·D that a radix-16 digit-recurrence divider subtracts from its partial remainder in each step. The quotient digit q is a signed digit in [−9, 9], and D is a 53-bit normalized significand. When the divisor is loaded, the block precomputes and stores only three multiples: 2D, 3D and 6D. Every other magnitude is rebuilt in each step. For magnitudes 4, 5, 7, 8 and 9, one adder/subtractor combines 6D with an operand picked from {0, D, 2D, 3D}. Magnitudes 0, 1, 2, 3 and 6 bypass the adder. The sign of the digit is then applied.

The output is a two's-complement word, registered one cycle after the step strobe. It is wide enough to hold ±9D without overflow and feeds the partial-remainder adder directly. Quotient selection, the remainder adders and quotient conversion live elsewhere.

Top module: `sdm_multiple_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `mult_o` is all zeros and `mult_vld_o` is low.
- R2: The digit code `digit_i` is a 5-bit two's-complement value. Only the values −9 to +9 are legal while `step_i` is high.
- R3: For a positive digit q presented with `step_i` high at a clock edge, `mult_o` equals q·D after that edge, where D is the stored divisor.
- R4: For a negative digit q, `mult_o` equals the two's-complement negation of |q|·D in the full output width.
- R5: Digit zero yields an all-zero `mult_o`.
- R6: `mult_o` is 58 bits, which is the divisor width plus five. With the all-ones divisor and q = ±9, the product is exact and the top bit reflects the sign of q.
- R7: A clock edge with `init_i` high loads `divisor_i` as D. While `init_i` is low, `divisor_i` has no effect on any later output.
- R8: `mult_vld_o` is high exactly in the cycles that follow an edge with `step_i` high. On back-to-back steps it stays high. After an edge with `step_i` low, `mult_o` keeps its previous value.
- R9: When `init_i` and `step_i` are high at the same edge, that step uses the previously stored divisor. The new divisor applies from the next step on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_i | input | 1 | Load the divisor and precompute 2D, 3D, 6D |
| divisor_i | input | 53 | Normalized divisor significand (top bit set) |
| step_i | input | 1 | Recurrence step strobe, digit is valid |
| digit_i | input | 5 | Signed quotient digit, two's complement, −9..+9 |
| mult_o | output | 58 | Registered q·D in two's complement |
| mult_vld_o | output | 1 | High in the cycle after a step |

## Verification
The assertions assume two things about the inputs. First, every digit presented with a step lies in −9..+9. Second, every loaded divisor is normalized with its top bit set, so a stored D is never zero and the sign checks on negative digits are meaningful. The bench drives only normalized divisors, including the minimum and all-ones values, and sweeps every legal digit value. It never presents the unused codes ±10..±16.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

   localparam int DIGIT_W   = 5;
   localparam int MAX_MAG   = 9;
   localparam int MAG_EXTRA = 4;

   // operand picked by the four-way selector
   typedef enum logic [1:0] {
      OPD_ZERO  = 2'd0,
      OPD_ONE   = 2'd1,
      OPD_TWO   = 2'd2,
      OPD_THREE = 2'd3
   } opd_sel_e;

   // how the magnitude is formed
   typedef enum logic [1:0] {
      PATH_DIRECT = 2'd0,   // operand itself, adder bypassed
      PATH_SIX    = 2'd1,   // stored 6D, adder bypassed
      PATH_ADD    = 2'd2,   // 6D + operand
      PATH_SUB    = 2'd3    // 6D - operand
   } path_e;

   typedef struct packed {
      logic     neg;
      path_e    path;
      opd_sel_e opd;
   } route_t;

   function automatic route_t decode_digit(input logic [DIGIT_W-1:0] code);
      route_t             r;
      logic [DIGIT_W-1:0] abs_v;
      abs_v  = code[DIGIT_W-1] ? (~code + 5'd1) : code;
      r.neg  = code[DIGIT_W-1];
      r.path = PATH_DIRECT;
      r.opd  = OPD_ZERO;
      case (abs_v)
         5'd1: begin r.path = PATH_DIRECT; r.opd = OPD_ONE;   end
         5'd2: begin r.path = PATH_DIRECT; r.opd = OPD_TWO;   end
         5'd3: begin r.path = PATH_DIRECT; r.opd = OPD_THREE; end
         5'd4: begin r.path = PATH_SUB;    r.opd = OPD_TWO;   end
         5'd5: begin r.path = PATH_SUB;    r.opd = OPD_ONE;   end
         5'd6: begin r.path = PATH_SIX;    r.opd = OPD_ZERO;  end
         5'd7: begin r.path = PATH_ADD;    r.opd = OPD_ONE;   end
         5'd8: begin r.path = PATH_ADD;    r.opd = OPD_TWO;   end
         5'd9: begin r.path = PATH_ADD;    r.opd = OPD_THREE; end
         default: begin r.path = PATH_DIRECT; r.opd = OPD_ZERO; end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/sdm_precompute.sv
module sdm_precompute #(
   parameter int DIV_W = 53,
   parameter int MAG_W = DIV_W + sdm_pkg::MAG_EXTRA
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DIV_W-1:0] div_i,
   output logic [MAG_W-1:0] d1_o,
   output logic [MAG_W-1:0] d2_o,
   output logic [MAG_W-1:0] d3_o,
   output logic [MAG_W-1:0] d6_o
);

   localparam int PAD_W = MAG_W - DIV_W;

   if (PAD_W < sdm_pkg::MAG_EXTRA) begin : g_bad_pad
      $error("sdm_precompute: MAG_W too narrow for 9D");
   end

   logic [MAG_W-1:0] one_w, two_w, three_w, six_w;

   always_comb begin
      one_w   = {{PAD_W{1'b0}}, div_i};
      two_w   = {one_w[MAG_W-2:0], 1'b0};
      three_w = one_w + two_w;
      six_w   = {three_w[MAG_W-2:0], 1'b0};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d1_o <= '0;
         d2_o <= '0;
         d3_o <= '0;
         d6_o <= '0;
      end else if (load_i) begin
         d1_o <= one_w;
         d2_o <= two_w;
         d3_o <= three_w;
         d6_o <= six_w;
      end
   end

   // R7: stored multiples only move on a load
   p_quiet_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(d1_o) && $stable(d2_o) && $stable(d3_o) && $stable(d6_o)));

endmodule

// File: rtl/sdm_magnitude_unit.sv
module sdm_magnitude_unit #(
   parameter int MAG_W = 57
) (
   input  logic             [MAG_W-1:0] d1_i,
   input  logic             [MAG_W-1:0] d2_i,
   input  logic             [MAG_W-1:0] d3_i,
   input  logic             [MAG_W-1:0] d6_i,
   input  sdm_pkg::route_t              route_i,
   output logic             [MAG_W-1:0] mag_o
);

   import sdm_pkg::*;

   logic [MAG_W-1:0] opd_w;
   logic [MAG_W-1:0] opd_cond_w;
   logic [MAG_W-1:0] sum_w;
   logic             sub_w;

   // four-way operand selector
   always_comb begin
      case (route_i.opd)
         OPD_ONE:   opd_w = d1_i;
         OPD_TWO:   opd_w = d2_i;
         OPD_THREE: opd_w = d3_i;
         default:   opd_w = '0;
      endcase
   end

   // single adder/subtractor around 6D
   always_comb begin
      sub_w      = (route_i.path == PATH_SUB);
      opd_cond_w = opd_w ^ {MAG_W{sub_w}};
      sum_w      = d6_i + opd_cond_w + {{(MAG_W-1){1'b0}}, sub_w};
   end

   always_comb begin
      case (route_i.path)
         PATH_DIRECT: mag_o = opd_w;
         PATH_SIX:    mag_o = d6_i;
         default:     mag_o = sum_w;
      endcase
   end

endmodule

// File: rtl/sdm_multiple_gen.sv
module sdm_multiple_gen #(
   parameter int DIV_W     = 53,
   parameter bit NEG_INVERT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  init_i,
   input  logic [DIV_W-1:0]      divisor_i,
   input  logic                  step_i,
   input  logic [4:0]            digit_i,
   output logic [DIV_W+4:0]      mult_o,
   output logic                  mult_vld_o
);

   import sdm_pkg::*;

   localparam int MAG_W = DIV_W + MAG_EXTRA;
   localparam int OUT_W = MAG_W + 1;

   if (DIV_W < 2) begin : g_bad_div
      $error("sdm_multiple_gen: DIV_W must be at least 2");
   end
   if (DIGIT_W != 5 || MAX_MAG != 9) begin : g_bad_digit
      $error("sdm_multiple_gen: digit set must be 5-bit [-9,9]");
   end

   logic   [MAG_W-1:0] d1_w, d2_w, d3_w, d6_w;
   logic   [MAG_W-1:0] mag_w;
   logic   [OUT_W-1:0] mag_ext_w;
   logic   [OUT_W-1:0] signed_w;
   route_t             route_w;

   sdm_precompute #(.DIV_W(DIV_W), .MAG_W(MAG_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (init_i),
      .div_i  (divisor_i),
      .d1_o   (d1_w),
      .d2_o   (d2_w),
      .d3_o   (d3_w),
      .d6_o   (d6_w)
   );

   always_comb route_w = decode_digit(digit_i);

   sdm_magnitude_unit #(.MAG_W(MAG_W)) u_mag (
      .d1_i    (d1_w),
      .d2_i    (d2_w),
      .d3_i    (d3_w),
      .d6_i    (d6_w),
      .route_i (route_w),
      .mag_o   (mag_w)
   );

   assign mag_ext_w = {1'b0, mag_w};

   if (NEG_INVERT) begin : g_neg_inv
      // conditional invert with carry-in
      assign signed_w = (mag_ext_w ^ {OUT_W{route_w.neg}}) +
                        {{(OUT_W-1){1'b0}}, route_w.neg};
   end else begin : g_neg_sub
      assign signed_w = route_w.neg ? (OUT_W'(0) - mag_ext_w) : mag_ext_w;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mult_o     <= '0;
         mult_vld_o <= 1'b0;
      end else begin
         mult_vld_o <= step_i;
         if (step_i) begin
            mult_o <= signed_w;
         end
      end
   end

   // R2: digit stays inside the legal set
   p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> ($signed(digit_i) >= -5'sd9 && $signed(digit_i) <= 5'sd9));

   // R7: only normalized divisors are loaded
   p_norm_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |-> divisor_i[DIV_W-1]);

   // R8: valid follows the step strobe
   p_vld_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> mult_vld_o);
   p_vld_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> !mult_vld_o);
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(mult_o));

   // R5: digit zero gives zero
   p_zero_digit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && digit_i == 5'd0) |=> (mult_o == '0));

   // R4: nonzero divisor and negative digit give a negative word
   p_neg_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && digit_i[4] && (d1_w != '0)) |=> mult_o[OUT_W-1]);

   // R6: positive digits never reach the sign bit
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !digit_i[4]) |=> !mult_o[OUT_W-1]);

endmodule

// File: tb/sdm_multiple_gen_bench.sv
module sdm_multiple_gen_bench;

   localparam int DW = 53;
   localparam int OW = DW + 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          init_i = 1'b0;
   logic [DW-1:0] divisor_i = '0;
   logic          step_i = 1'b0;
   logic [4:0]    digit_i = '0;
   logic [OW-1:0] mult_o;
   logic          mult_vld_o;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   sdm_multiple_gen u_sdm_multiple_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_i     (init_i),
      .divisor_i  (divisor_i),
      .step_i     (step_i),
      .digit_i    (digit_i),
      .mult_o     (mult_o),
      .mult_vld_o (mult_vld_o)
   );

   function automatic logic [OW-1:0] expect_mult(input logic [DW-1:0] d, input int q);
      longint     p;
      logic [63:0] t;
      p = longint'({11'b0, d}) * longint'(q);
      t = p;
      return t[OW-1:0];
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset mult", 64'(mult_o), 64'd0);
      check("R1 reset vld", 64'(mult_vld_o), 64'd1 - 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset mult", 64'(mult_o), 64'd0);
      check("R1 after reset vld", 64'(mult_vld_o), 64'd0);
   endtask

   task automatic do_init(input logic [DW-1:0] d);
      init_i    = 1'b1;
      divisor_i = d;
      @(posedge clk);
      @(negedge clk);
      init_i = 1'b0;
   endtask

   // apply one step at a negedge, check after the next edge
   task automatic do_step(input int q, input logic [DW-1:0] d, input string tag, input bit keep);
      step_i  = 1'b1;
      digit_i = q[4:0];
      @(posedge clk);
      @(negedge clk);
      if (!keep) step_i = 1'b0;
      check(tag, 64'(mult_o), 64'(expect_mult(d, q)));
      check({tag, " vld"}, 64'(mult_vld_o), 64'd1);
   endtask

   task automatic t_positive(input logic [DW-1:0] d);
      for (int q = 1; q <= 9; q++) do_step(q, d, $sformatf("R3 pos q=%0d", q), 1'b0);
   endtask

   task automatic t_negative(input logic [DW-1:0] d);
      for (int q = 1; q <= 9; q++) do_step(-q, d, $sformatf("R4 neg q=-%0d", q), 1'b0);
   endtask

   task automatic t_zero(input logic [DW-1:0] d);
      do_step(-7, d, "R5 prior nonzero", 1'b0);
      do_step(0, d, "R5 zero digit", 1'b0);
   endtask

   task automatic t_max_width();
      logic [DW-1:0] dmax;
      dmax = '1;
      do_init(dmax);
      do_step(9, dmax, "R6 max +9", 1'b0);
      check("R6 sign +9", 64'(mult_o[OW-1]), 64'd0);
      do_step(-9, dmax, "R6 max -9", 1'b0);
      check("R6 sign -9", 64'(mult_o[OW-1]), 64'd1);
   endtask

   task automatic t_hold(input logic [DW-1:0] d);
      do_step(7, d, "R8 before idle", 1'b0);
      digit_i = 5'd2;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         @(negedge clk);
         check("R8 idle vld", 64'(mult_vld_o), 64'd0);
         check("R8 idle hold", 64'(mult_o), 64'(expect_mult(d, 7)));
      end
   endtask

   task automatic t_back_to_back(input logic [DW-1:0] d);
      do_step(4, d, "R8 b2b first", 1'b1);
      do_step(-5, d, "R8 b2b second", 1'b1);
      do_step(8, d, "R8 b2b third", 1'b0);
      @(posedge clk);
      @(negedge clk);
      check("R8 b2b drop", 64'(mult_vld_o), 64'd0);
   endtask

   task automatic t_ignore_divisor(input logic [DW-1:0] d);
      divisor_i = 53'h1F_FFFF_0000_1234;
      @(posedge clk);
      @(negedge clk);
      do_step(5, d, "R7 divisor ignored", 1'b0);
      do_step(-3, d, "R7 divisor ignored neg", 1'b0);
   endtask

   task automatic t_overlap(input logic [DW-1:0] d_old, input logic [DW-1:0] d_new);
      init_i    = 1'b1;
      divisor_i = d_new;
      do_step(3, d_old, "R9 overlap uses old", 1'b0);
      init_i = 1'b0;
      do_step(3, d_new, "R9 next uses new", 1'b0);
      do_step(-6, d_new, "R7 new divisor -6", 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] da, db, dmin;
      da   = 53'h1A_BCDE_F012_3456;
      db   = 53'h13_5790_2468_ACE1;
      dmin = 53'h10_0000_0000_0000;
      @(negedge clk);
      do_reset();
      do_init(da);
      t_positive(da);
      t_negative(da);
      t_zero(da);
      do_init(dmin);
      do_step(9, dmin, "R3 min divisor +9", 1'b0);
      do_step(-1, dmin, "R4 min divisor -1", 1'b0);
      t_max_width();
      do_init(db);
      t_hold(db);
      t_back_to_back(db);
      t_ignore_divisor(db);
      t_overlap(db, da);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule